// File: doc/BRIEF.md
# Frame Phase Status Capture

This block measures where a serial TDM port sits within its frame, so that software can compare it with the frame timing of a parallel port. A free-running counter in the serial clock domain advances once per tick of a clock that runs at twice the serial bit-cell rate. Its lowest bit is therefore the level of the half-rate serial clock, and the bits above it count whole serial cycles. A serial frame pulse clears the counter and inverts a frame-parity bit. Together these form an 11-bit phase word.

The parallel-port frame pulse is synchronised into the serial domain and divided by two. On every second pulse the phase word is frozen into a snapshot. A toggle handshake carries that snapshot into the CPU clock domain, where a holding register loads all bits in one cycle. The CPU reads the holding register through two byte-wide, read-only addresses. Reads are registered.

Because the holding register can change between two byte reads, software reads the word twice and accepts it when both reads agree.

Top module: `frame_phase_status`

## Requirements
- R1: After reset, reads of both status addresses return 0x00.
- R2: Without a serial frame pulse, the 10-bit phase field (bit 0 = half-rate clock level, bits 9..1 = cycle count) rises by one on every serial clock edge and wraps from 1023 to 0. The parity bit 10 is unchanged.
- R3: A serial frame pulse sampled high at a serial clock edge sets the phase field to 0 at that edge and inverts bit 10.
- R4: Only the even-numbered rising edges of the parallel frame pulse take a snapshot (the 2nd, 4th, and so on after reset). The odd-numbered ones leave the readable value unchanged.
- R5: A snapshot holds the 11-bit phase word produced by the serial clock edge one cycle after the edge that first samples the parallel pulse high.
- R6: With both clocks equal, a read issued at the 5th edge after the sampling edge of a capturing parallel pulse returns the previous value. A read issued at the 6th edge returns the new snapshot.
- R7: Address 8 returns bits 7..0. Address 9 returns bits 10..8 in its low three bits, with bits 7..3 zero. Every other address returns 0x00.
- R8: Read data updates only on a CPU clock edge at which the read enable is high, and it holds its value otherwise.
- R9: The holding register changes only when a new snapshot arrives, so repeated reads between captures return identical bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk_i | input | 1 | Serial-side clock, twice the serial bit-cell rate |
| ser_rst_n_i | input | 1 | Active-low asynchronous reset, serial domain |
| ser_fp_i | input | 1 | Serial frame pulse, one clock wide |
| par_fp_i | input | 1 | Parallel-port frame pulse, asynchronous |
| cpu_clk_i | input | 1 | CPU register clock |
| cpu_rst_n_i | input | 1 | Active-low asynchronous reset, CPU domain |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Register address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench drives both clocks from one 250 MHz source, so every latency is a fixed number of edges. The counter value it expects in a snapshot is the one its model holds one edge after the parallel pulse is sampled. A new snapshot first becomes readable at the sixth edge after that sampling edge, and the bench probes both the fifth and the sixth edge to pin that latency exactly. Read data appears after the edge that carries the read enable, so every read is sampled at the following falling edge. Each value is compared against the model's value at that point.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } rd_sel_e;

    // Selects one byte of a zero-extended status word.
    function automatic logic [7:0] pick_byte(input logic [15:0] word, input rd_sel_e sel);
        logic [7:0] r;
        unique case (sel)
            SEL_LO:  r = word[7:0];
            SEL_HI:  r = word[15:8];
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fps_phase_counter.sv
module fps_phase_counter #(
    parameter int CYC_W = 9,
    localparam int ST_W = CYC_W + 2
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            frame_i,
    output logic [ST_W-1:0] status_o
);

    typedef struct packed {
        logic             parity;
        logic [CYC_W:0]   ph;      // {cycle count, half-phase}
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_i) begin
            s_d.ph     = '0;
            s_d.parity = ~s_q.parity;
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign status_o = {s_q.parity, s_q.ph};

endmodule

// File: rtl/fps_capture.sv
module fps_capture #(
    parameter int ST_W        = 11,
    parameter int SYNC_STAGES = 2,
    parameter int CAPTURE_DIV = 2,
    localparam int DIV_W      = (CAPTURE_DIV > 1) ? $clog2(CAPTURE_DIV) : 1
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            pfp_i,
    input  logic [ST_W-1:0] status_i,
    output logic [ST_W-1:0] snap_o,
    output logic            tgl_o,
    output logic            cap_stb_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [DIV_W-1:0]       div;
        logic [ST_W-1:0]        snap;
        logic                   tgl;
    } cap_t;

    cap_t s_d, s_q;
    logic rise;
    logic last_slot;

    // The divider variant depends on the capture ratio.
    generate
        if (CAPTURE_DIV > 1) begin : g_div
            assign last_slot = (s_q.div == DIV_W'(CAPTURE_DIV - 1));
        end else begin : g_nodiv
            assign last_slot = 1'b1;
        end
    endgenerate

    assign rise      = s_q.sync[SYNC_STAGES-1] & ~s_q.prev;
    assign cap_stb_o = rise & last_slot;

    always_comb begin
        s_d         = s_q;
        s_d.sync[0] = pfp_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            s_d.sync[k] = s_q.sync[k-1];
        end
        s_d.prev = s_q.sync[SYNC_STAGES-1];
        if (rise) begin
            if (last_slot) begin
                s_d.div  = '0;
                s_d.snap = status_i;
                s_d.tgl  = ~s_q.tgl;
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign snap_o = s_q.snap;
    assign tgl_o  = s_q.tgl;

endmodule

// File: rtl/fps_cdc_load.sv
module fps_cdc_load #(
    parameter int ST_W        = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            tgl_i,
    input  logic [ST_W-1:0] snap_i,
    output logic [ST_W-1:0] hold_o,
    output logic            load_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [ST_W-1:0]        hold;
    } xfer_t;

    xfer_t s_d, s_q;

    // snap_i is stable for many cycles before the toggle is seen here.
    assign load_o = s_q.sync[SYNC_STAGES-1] ^ s_q.prev;

    always_comb begin
        s_d         = s_q;
        s_d.sync[0] = tgl_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            s_d.sync[k] = s_q.sync[k-1];
        end
        s_d.prev = s_q.sync[SYNC_STAGES-1];
        if (load_o) begin
            s_d.hold = snap_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign hold_o = s_q.hold;

endmodule

// File: rtl/fps_read_port.sv
module fps_read_port
    import fps_pkg::*;
#(
    parameter int ST_W    = 11,
    parameter int ADDR_W  = 4,
    parameter int LO_ADDR = 8,
    parameter int HI_ADDR = 9
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [ST_W-1:0]   hold_i,
    output logic [7:0]        rd_data_o
);

    typedef struct packed {
        logic [7:0] data;
    } rd_t;

    rd_t        s_d, s_q;
    rd_sel_e    sel;
    logic [15:0] word;

    assign word = 16'(hold_i);

    always_comb begin
        if (rd_addr_i == ADDR_W'(LO_ADDR))      sel = SEL_LO;
        else if (rd_addr_i == ADDR_W'(HI_ADDR)) sel = SEL_HI;
        else                                    sel = SEL_NONE;
    end

    always_comb begin
        s_d = s_q;
        if (rd_en_i) begin
            s_d.data = pick_byte(word, sel);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign rd_data_o = s_q.data;

endmodule

// File: rtl/frame_phase_status.sv
module frame_phase_status #(
    parameter int CYC_W       = 9,
    parameter int SYNC_STAGES = 2,
    parameter int CAPTURE_DIV = 2,
    parameter int ADDR_W      = 4,
    parameter int LO_ADDR     = 8,
    parameter int HI_ADDR     = 9
) (
    input  logic              ser_clk_i,
    input  logic              ser_rst_n_i,
    input  logic              ser_fp_i,
    input  logic              par_fp_i,
    input  logic              cpu_clk_i,
    input  logic              cpu_rst_n_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    localparam int ST_W = CYC_W + 2;

    logic [ST_W-1:0] status_w;
    logic [ST_W-1:0] snap_w;
    logic [ST_W-1:0] hold_w;
    logic            tgl_w;
    logic            cap_stb_w;
    logic            load_w;

    fps_phase_counter #(.CYC_W(CYC_W)) u_cnt (
        .clk_i    (ser_clk_i),
        .rst_n_i  (ser_rst_n_i),
        .frame_i  (ser_fp_i),
        .status_o (status_w)
    );

    fps_capture #(
        .ST_W        (ST_W),
        .SYNC_STAGES (SYNC_STAGES),
        .CAPTURE_DIV (CAPTURE_DIV)
    ) u_cap (
        .clk_i     (ser_clk_i),
        .rst_n_i   (ser_rst_n_i),
        .pfp_i     (par_fp_i),
        .status_i  (status_w),
        .snap_o    (snap_w),
        .tgl_o     (tgl_w),
        .cap_stb_o (cap_stb_w)
    );

    fps_cdc_load #(
        .ST_W        (ST_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xfer (
        .clk_i   (cpu_clk_i),
        .rst_n_i (cpu_rst_n_i),
        .tgl_i   (tgl_w),
        .snap_i  (snap_w),
        .hold_o  (hold_w),
        .load_o  (load_w)
    );

    fps_read_port #(
        .ST_W    (ST_W),
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_rd (
        .clk_i     (cpu_clk_i),
        .rst_n_i   (cpu_rst_n_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .hold_i    (hold_w),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int CYC_W   = 9,
    parameter int ADDR_W  = 4,
    parameter int HI_ADDR = 9,
    localparam int ST_W   = CYC_W + 2
) (
    input logic              ser_clk_i,
    input logic              ser_rst_n_i,
    input logic              ser_fp_i,
    input logic [ST_W-1:0]   status_i,
    input logic [ST_W-1:0]   snap_i,
    input logic              cap_stb_i,
    input logic              cpu_clk_i,
    input logic              cpu_rst_n_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [7:0]        rd_data_i,
    input logic [ST_W-1:0]   hold_i,
    input logic              load_i
);

    // R2: steady advance of the phase field, parity kept
    p_step_r2: assert property (@(posedge ser_clk_i) disable iff (!ser_rst_n_i)
        !ser_fp_i |=> (status_i[CYC_W:0] == (CYC_W+1)'($past(status_i[CYC_W:0]) + 1'b1))
                      && (status_i[ST_W-1] == $past(status_i[ST_W-1])));

    // R3: frame pulse clears the phase field and flips parity
    p_frame_r3: assert property (@(posedge ser_clk_i) disable iff (!ser_rst_n_i)
        ser_fp_i |=> (status_i[CYC_W:0] == '0) && (status_i[ST_W-1] != $past(status_i[ST_W-1])));

    // R4: snapshot moves only on a capture strobe
    p_snap_r4: assert property (@(posedge ser_clk_i) disable iff (!ser_rst_n_i)
        !cap_stb_i |=> $stable(snap_i));

    // R7: unused upper bits of the high byte read as zero
    p_pad_r7: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_n_i)
        (rd_en_i && (rd_addr_i == ADDR_W'(HI_ADDR))) |=> ((rd_data_i >> (ST_W - 8)) == 8'h00));

    // R8: no read strobe, no change of read data
    p_idle_r8: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_n_i)
        !rd_en_i |=> $stable(rd_data_i));

    // R9: holding register moves only on a handshake load
    p_hold_r9: assert property (@(posedge cpu_clk_i) disable iff (!cpu_rst_n_i)
        !load_i |=> $stable(hold_i));

endmodule

bind frame_phase_status fps_checker #(
    .CYC_W   (CYC_W),
    .ADDR_W  (ADDR_W),
    .HI_ADDR (HI_ADDR)
) u_chk (
    .ser_clk_i   (ser_clk_i),
    .ser_rst_n_i (ser_rst_n_i),
    .ser_fp_i    (ser_fp_i),
    .status_i    (status_w),
    .snap_i      (snap_w),
    .cap_stb_i   (cap_stb_w),
    .cpu_clk_i   (cpu_clk_i),
    .cpu_rst_n_i (cpu_rst_n_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_i   (rd_data_o),
    .hold_i      (hold_w),
    .load_i      (load_w)
);

// File: tb/frame_phase_status_tb.sv
`timescale 1ns/1ps
module frame_phase_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfp = 1'b0;
    logic       pfp = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int frame_len = 0;

    // Reference model
    logic [9:0]  m_ph;
    logic        m_par;
    logic [10:0] exp_snap;
    int          m_pulses;
    logic        m_pend;

    always #2 clk = ~clk;   // 250 MHz

    frame_phase_status u_dut (
        .ser_clk_i   (clk),
        .ser_rst_n_i (rst_n),
        .ser_fp_i    (sfp),
        .par_fp_i    (pfp),
        .cpu_clk_i   (clk),
        .cpu_rst_n_i (rst_n),
        .rd_en_i     (rd_en),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data)
    );

    // R2/R3 counter model, R4/R5 capture model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = '0; m_par = 1'b0; exp_snap = '0; m_pulses = 0; m_pend = 1'b0;
        end else begin
            if (sfp) begin m_ph = '0; m_par = ~m_par; end
            else     m_ph = m_ph + 10'd1;
            if (m_pend) begin
                m_pulses = m_pulses + 1;
                if (m_pulses % 2 == 0) exp_snap = {m_par, m_ph};
            end
            m_pend = pfp;
        end
    end

    // Serial frame pulse generator
    initial begin
        forever begin
            if (frame_len == 0) @(negedge clk);
            else begin
                repeat (frame_len - 1) @(negedge clk);
                sfp = 1'b1;
                @(negedge clk);
                sfp = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic par_pulse();
        @(negedge clk) pfp = 1'b1;
        @(negedge clk) pfp = 1'b0;
    endtask

    task automatic read_word(input string req);
        logic [7:0] lo, hi, lo2, hi2;
        rd(4'd8, lo);
        rd(4'd9, hi);
        check(req, {hi[2:0], lo}, exp_snap);
        check("R7 high pad", hi[7:3], 0);
        rd(4'd8, lo2);
        rd(4'd9, hi2);
        check("R9 repeat read", {hi2, lo2}, {hi, lo});
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [10:0] old;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd8, d); check("R1 low byte after reset", d, 0);
        rd(4'd9, d); check("R1 high byte after reset", d, 0);

        // R4: first pulse after reset does not capture
        par_pulse();
        repeat (10) @(negedge clk);
        rd(4'd8, d); check("R4 first pulse ignored", d, 0);

        // R7: every other address reads zero
        for (int a = 0; a < 16; a++) begin
            if (a != 8 && a != 9) begin
                rd(4'(a), d);
                check("R7 unmapped address", d, 0);
            end
        end

        // R2 R3 R5: sweep pulse placement over several frame lengths
        for (int f = 0; f < 3; f++) begin
            frame_len = (f == 0) ? 64 : (f == 1) ? 50 : 1024;
            for (int i = 0; i < 120; i++) begin
                par_pulse();
                repeat (8 + (i % 13) + f * 3) @(negedge clk);
                read_word("R5 snapshot vs model (R2/R3 phase, parity)");
            end
        end

        // R2: wrap without serial frame pulses
        frame_len = 0;
        for (int i = 0; i < 24; i++) begin
            par_pulse();
            repeat (300 + i) @(negedge clk);
            read_word("R2 wrap snapshot");
        end

        // R4: odd pulse leaves value unchanged
        frame_len = 40;
        if (m_pulses % 2 != 0) begin par_pulse(); repeat (10) @(negedge clk); end
        old = exp_snap;
        par_pulse();
        repeat (12) @(negedge clk);
        rd(4'd8, d); check("R4 odd pulse no capture", d, old[7:0]);

        // R6: load latency
        old = exp_snap;
        par_pulse();
        repeat (4) @(negedge clk);
        rd(4'd8, d); check("R6 read at 5th edge old", d, old[7:0]);
        rd(4'd8, d); check("R6 read at 6th edge new", d, exp_snap[7:0]);
        rd(4'd9, d); check("R6 high byte new", d, {5'b0, exp_snap[10:8]});

        // R8: data holds while read enable is low
        rd(4'd8, d);
        rd_addr = 4'd9;
        repeat (5) @(negedge clk);
        check("R8 hold without strobe", rd_data, d);
        rd_addr = 4'd3;
        repeat (3) @(negedge clk);
        check("R8 hold on other address", rd_data, d);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule